// File: doc/BRIEF.md
# Mirrored-Index Sine Sequencer

This block produces a coarse digital sine wave with eight samples per period. A 3-bit phase register visits its eight values in a folded order: it counts up from 0 to 3, jumps to 7, and counts down to 4. Because of this order, the two low phase bits alone address a four-entry magnitude table, and each table entry is read twice in every period. The top phase bit selects whether the magnitude is output as a positive or a negative value.

The phase advances once for each clock edge on which the step enable is high. A clock generator can therefore set the output frequency by pulsing the enable. The sample output is registered. A cycle-start strobe marks the first sample slot of each new period. A parameter selects whether the phase register is stored in binary (3 flops) or one-hot (8 flops). The ports behave the same in both encodings.

Top module: `mirror_sine_gen`

## Requirements
- R1: While the asynchronous active-high reset `rst` is high, and as soon as it rises, `phase` reads 0, `sample` reads 0 and `cycleStart` reads 0.
- R2: On each rising clock edge with `stepEn` high, `phase` moves to the next value of the repeating order 0, 1, 2, 3, 7, 6, 5, 4.
- R3: On a rising edge with `stepEn` low, `phase` keeps its value.
- R4: The magnitude is taken from a table addressed by `phase[1:0]` only. Index 0 gives 49, 1 gives 117, 2 gives 117 and 3 gives 49 (127·sin((2k+1)π/8) rounded). Each entry therefore appears twice per period.
- R5: When `phase[2]` is 0 the sample is +magnitude. When it is 1 the sample is -magnitude, as a 9-bit two's-complement value.
- R6: `sample` is registered. After every rising edge it holds the value selected by the phase that was present before that edge. It updates whether or not `stepEn` is high.
- R7: `cycleStart` is high for exactly the one clock that follows an enabled step from phase 4 to phase 0. It is low at all other times.
- R8: With parameter `ONE_HOT` set to 1 (8-flop state), `phase`, `sample` and `cycleStart` are identical, cycle for cycle, to the binary build under the same stimulus.
- R9: In the one-hot build, a state with no bit set or with several bits set returns to phase 0 on the next edge with `stepEn` high. `cycleStart` stays low on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| stepEn | input | 1 | Advance the phase on this edge |
| sample | output | 9 | Signed sine sample, two's complement |
| phase | output | 3 | Current phase value |
| cycleStart | output | 1 | One-clock pulse after the 4-to-0 wrap |

## Verification
The phase changes on the same edge as the enabled step, so the bench reads it at the falling edge right after that edge. The sample and the cycle-start strobe each pass through one more register. The bench model therefore computes them from the phase it held before the edge and compares them at that same falling edge. The bench checks reset, which is asynchronous, a couple of nanoseconds after `rst` rises, with no clock edge in between. A one-hot instance runs alongside the binary one under identical enables, and its ports are compared with the binary instance's ports at every check point.

// File: rtl/mirror_sine_pkg.sv
package mirror_sine_pkg;
  localparam int PHASE_W    = 3;
  localparam int NUM_PHASES = 1 << PHASE_W;
  localparam int IDX_W      = PHASE_W - 1;
  localparam int MAG_W      = 8;
  localparam int SAMPLE_W   = MAG_W + 1;

  typedef struct packed {
    logic [IDX_W-1:0] tableIdx;
    logic             negate;
    logic             wrapStep;
  } seqStrobe_t;

  // Folded order: up 0..3, jump to 7, down to 4, back to 0.
  function automatic logic [PHASE_W-1:0] nextPhase(input logic [PHASE_W-1:0] p);
    logic [PHASE_W-1:0] n;
    if (!p[PHASE_W-1]) n = (p == PHASE_W'(NUM_PHASES/2 - 1)) ? PHASE_W'(NUM_PHASES - 1) : p + 1'b1;
    else               n = (p == PHASE_W'(NUM_PHASES/2))     ? '0                        : p - 1'b1;
    return n;
  endfunction

  function automatic logic [MAG_W-1:0] magnitude(input logic [IDX_W-1:0] idx);
    logic [MAG_W-1:0] m;
    case (idx)
      2'd0:    m = MAG_W'(49);
      2'd1:    m = MAG_W'(117);
      2'd2:    m = MAG_W'(117);
      default: m = MAG_W'(49);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sine_phase_ctrl.sv
module sine_phase_ctrl
  import mirror_sine_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stepEn,
  output logic [PHASE_W-1:0] phase,
  output logic               phaseLegal,
  output seqStrobe_t         strobes
);

  generate
    if (ONE_HOT) begin : g_hot
      logic [NUM_PHASES-1:0] hotQ;
      logic [NUM_PHASES-1:0] hotNext;
      logic [PHASE_W-1:0]    hotEnc;

      always_comb begin
        hotNext = '0;
        for (int i = 0; i < NUM_PHASES; i++)
          if (hotQ[i]) hotNext[nextPhase(PHASE_W'(i))] = 1'b1;
      end

      always_comb begin
        hotEnc = '0;
        for (int i = 0; i < NUM_PHASES; i++)
          if (hotQ[i]) hotEnc = hotEnc | PHASE_W'(i);
      end

      always_ff @(posedge clk or posedge rst) begin
        if (rst)         hotQ <= NUM_PHASES'(1);
        else if (stepEn) hotQ <= $onehot(hotQ) ? hotNext : NUM_PHASES'(1);
      end

      assign phase      = hotEnc;
      assign phaseLegal = $onehot(hotQ);
    end else begin : g_bin
      logic [PHASE_W-1:0] binQ;

      always_ff @(posedge clk or posedge rst) begin
        if (rst)         binQ <= '0;
        else if (stepEn) binQ <= nextPhase(binQ);
      end

      assign phase      = binQ;
      assign phaseLegal = 1'b1;
    end
  endgenerate

  always_comb begin
    strobes.tableIdx = phase[IDX_W-1:0];
    strobes.negate   = phase[PHASE_W-1];
    strobes.wrapStep = stepEn && phaseLegal && (phase == PHASE_W'(NUM_PHASES/2));
  end

endmodule

// File: rtl/sine_sample_path.sv
module sine_sample_path
  import mirror_sine_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  seqStrobe_t                 strobes,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic                       cycleStart
);

  logic signed [SAMPLE_W-1:0] posMag;
  logic signed [SAMPLE_W-1:0] sampleNext;

  always_comb begin
    posMag     = $signed({1'b0, magnitude(strobes.tableIdx)});
    sampleNext = strobes.negate ? -posMag : posMag;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sample     <= '0;
      cycleStart <= 1'b0;
    end else begin
      sample     <= sampleNext;
      cycleStart <= strobes.wrapStep;
    end
  end

endmodule

// File: rtl/mirror_sine_gen.sv
module mirror_sine_gen
  import mirror_sine_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stepEn,
  output logic signed [SAMPLE_W-1:0] sample,
  output logic [PHASE_W-1:0]         phase,
  output logic                       cycleStart
);

  seqStrobe_t strobes;
  logic       phaseLegal;

  sine_phase_ctrl #(.ONE_HOT(ONE_HOT)) uCtrl (
    .clk        (clk),
    .rst        (rst),
    .stepEn     (stepEn),
    .phase      (phase),
    .phaseLegal (phaseLegal),
    .strobes    (strobes)
  );

  sine_sample_path uPath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .sample     (sample),
    .cycleStart (cycleStart)
  );

endmodule

// File: rtl/mirror_sine_checker.sv
module mirror_sine_checker
  import mirror_sine_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic                       stepEn,
  input logic [PHASE_W-1:0]         phase,
  input logic                       phaseLegal,
  input logic signed [SAMPLE_W-1:0] sample,
  input logic                       cycleStart
);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!stepEn && phaseLegal) |=> $stable(phase));

  assert_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (stepEn && phaseLegal && phase < 3'd3) |=> (phase == $past(phase) + 3'd1));

  assert_jump_R2: assert property (@(posedge clk) disable iff (rst)
    (stepEn && phaseLegal && phase == 3'd3) |=> (phase == 3'd7));

  assert_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (stepEn && phaseLegal && phase > 3'd4) |=> (phase == $past(phase) - 3'd1));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (stepEn && phaseLegal && phase == 3'd4) |=> (phase == 3'd0 && cycleStart));

  assert_no_stray_start_R7: assert property (@(posedge clk) disable iff (rst)
    !(stepEn && phaseLegal && phase == 3'd4) |=> !cycleStart);

  assert_sign_R5: assert property (@(posedge clk) disable iff (rst)
    phaseLegal |=> (sample[SAMPLE_W-1] == $past(phase[PHASE_W-1])));

  assert_outer_mag_R4: assert property (@(posedge clk) disable iff (rst)
    (phaseLegal && (phase[1:0] == 2'd0 || phase[1:0] == 2'd3))
      |=> (sample == 9'sd49 || sample == -9'sd49));

  assert_inner_mag_R4: assert property (@(posedge clk) disable iff (rst)
    (phaseLegal && (phase[1:0] == 2'd1 || phase[1:0] == 2'd2))
      |=> (sample == 9'sd117 || sample == -9'sd117));

endmodule

bind mirror_sine_gen mirror_sine_checker chk (
  .clk        (clk),
  .rst        (rst),
  .stepEn     (stepEn),
  .phase      (phase),
  .phaseLegal (phaseLegal),
  .sample     (sample),
  .cycleStart (cycleStart)
);

// File: tb/tb_mirror_sine_gen.sv
`timescale 1ns/1ps
module tb_mirror_sine_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stepEn = 1'b0;
  logic signed [8:0] sampleB, sampleH;
  logic [2:0] phaseB, phaseH;
  logic startB, startH;

  int checks = 0;
  int fails  = 0;
  int expPos = 0;
  int expSample = 0;
  int expStart = 0;

  always #10 clk = ~clk;

  mirror_sine_gen #(.ONE_HOT(1'b0)) dut (
    .clk(clk), .rst(rst), .stepEn(stepEn),
    .sample(sampleB), .phase(phaseB), .cycleStart(startB));

  mirror_sine_gen #(.ONE_HOT(1'b1)) dutHot (
    .clk(clk), .rst(rst), .stepEn(stepEn),
    .sample(sampleH), .phase(phaseH), .cycleStart(startH));

  function automatic int phaseOf(input int pos);
    return (pos < 4) ? pos : 11 - pos;
  endfunction

  function automatic int sineOf(input int pos);
    real r;
    r = 127.0 * $sin((2.0 * pos + 1.0) * 3.14159265358979 / 8.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    check("R2/R3 phase", int'(phaseB), phaseOf(expPos));
    check("R4/R5/R6 sample", int'(sampleB), expSample);
    check("R7 cycleStart", int'(startB), expStart);
    check("R8 one-hot phase", int'(phaseH), int'(phaseB));
    check("R8 one-hot sample", int'(sampleH), int'(sampleB));
    check("R8 one-hot cycleStart", int'(startH), int'(startB));
  endtask

  task automatic tick(input logic v);
    stepEn = v;
    @(posedge clk);
    expSample = sineOf(expPos);
    expStart  = (v && expPos == 7) ? 1 : 0;
    if (v) expPos = (expPos + 1) % 8;
    @(negedge clk);
    checkAll();
  endtask

  task automatic doReset();
    @(negedge clk);
    stepEn = 1'b0;
    rst = 1'b1;
    #2;
    check("R1 reset phase", int'(phaseB), 0);
    check("R1 reset sample", int'(sampleB), 0);
    check("R1 reset cycleStart", int'(startB), 0);
    check("R1 reset one-hot phase", int'(phaseH), 0);
    check("R1 reset one-hot sample", int'(sampleH), 0);
    @(negedge clk);
    rst = 1'b0;
    expPos = 0; expSample = 0; expStart = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    doReset();
    // R2 R4 R5 R6 R7: three full periods with continuous enable
    for (int i = 0; i < 24; i++) tick(1'b1);
    // R3: irregular enable patterns
    for (int i = 0; i < 60; i++) tick((i % 5) != 3 && (i % 7) != 0);
    for (int i = 0; i < 20; i++) tick(i[0]);
    // R3: long hold
    for (int i = 0; i < 6; i++) tick(1'b0);
    // R1: asynchronous reset in mid-period
    for (int i = 0; i < 5; i++) tick(1'b1);
    doReset();
    for (int i = 0; i < 10; i++) tick(1'b1);

    // R9: several bits set in the one-hot state
    doReset();
    force dutHot.uCtrl.g_hot.hotQ = 8'b0110_0000;
    #1 release dutHot.uCtrl.g_hot.hotQ;
    stepEn = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 multi-bit recovers to 0", int'(phaseH), 0);
    check("R9 no cycleStart on recovery", int'(startH), 0);
    @(posedge clk); @(negedge clk);
    check("R9 steps on after recovery", int'(phaseH), 1);
    check("R9 sample from phase 0", int'(sampleH), 49);

    // R9: no bit set in the one-hot state
    doReset();
    force dutHot.uCtrl.g_hot.hotQ = 8'b0000_0000;
    #1 release dutHot.uCtrl.g_hot.hotQ;
    stepEn = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 empty state recovers to 0", int'(phaseH), 0);
    check("R9 no cycleStart on empty recovery", int'(startH), 0);
    stepEn = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule